// File: doc/BRIEF.md
# Receive DMA Channel with Station Address Filter

This block is the receive side of a packet network port. It takes the 16-bit words of an incoming packet one at a time. It checks the destination byte of the first word against an 8-bit station address read from static switch inputs. It then copies the words of accepted packets into memory through a simple request/acknowledge write port. The final word of every packet is the check word. An external checker computes it and reports, together with that word, whether the packet's check passed.

Software programs three things: a buffer address, a word count written as the one's complement of the number of words expected (the check word included), and a control/status register. It then sets enable. The channel stops and reports done once an accepted packet ends or an error is found. A raised interrupt enable turns done into an interrupt request. Packets for other stations are dropped without a trace and the channel stays armed. A promiscuous bit switches the filter off.

Top module: `rx_dma`

## Requirements
- R1: After synchronous reset the count, address and control/status registers read 0, and `irq` and `mem_req` are 0.
- R2: Register select 0 reads the 10-bit word count in bits 9..0 (bits above read 0). Select 1 reads the buffer address, with bit 0 always 0. Select 2 reads control/status: error 15, done 7, interrupt enable 6, promiscuous 1, enable 0. Software can write only bits 6, 1 and 0. Select 3 reads the switch station address in bits 7..0 and ignores writes.
- R3: With enable 1 and promiscuous 0, a packet is accepted only if the high byte of its first word equals the station address. Any other packet is discarded up to its last word, with no write, no count change and no done, and enable stays 1 for the next packet.
- R4: With promiscuous 1, every packet is accepted whatever its destination byte.
- R5: Each word of an accepted packet except the last is written, in arrival order, to the current buffer address. `mem_addr` and `mem_data` stay stable while `mem_req` waits for `mem_ack`, and every acknowledged write advances the address by 2.
- R6: Every counted word of an accepted packet, the last word included, increments the word count by 1. Loading the one's complement of N therefore reads 0x3FF after N words.
- R7: The last word of a packet (`rx_last`=1) is counted but never written. If `rx_crc_ok` is 1 with it, done is set and error stays 0.
- R8: A last word with `rx_crc_ok`=0 sets both error and done.
- R9: A word of an accepted packet that arrives while the count reads 0x3FF sets error and done. That word is neither written nor counted.
- R10: A word of an accepted packet that arrives while an earlier write still lacks `mem_ack` sets error and done, and the pending request is withdrawn.
- R11: Setting done clears enable. `irq` equals done AND interrupt enable. Any write to control/status clears done and error.
- R12: While enable is 0, incoming words cause no write and no count change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 count, 1 address, 2 control/status, 3 station |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_sel` |
| station_sw | input | 8 | Static station address switches |
| rx_valid | input | 1 | Received word valid this cycle |
| rx_data | input | 16 | Received word |
| rx_last | input | 1 | This word is the packet's check word |
| rx_crc_ok | input | 1 | Packet check passed (valid with `rx_last`) |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory write byte address |
| mem_data | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory accepted the write |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that a waiting write keeps its address and data, and that a check word never starts a write. They also check that filtered or disabled words never start one, that the counter never advances past all ones, and that done rising always coincides with enable being clear. Only the bench scenarios show the data landing at the right addresses in order and the final count values. They also show how each ending is classified (good, bad check, overflow, late memory), that `irq` follows interrupt enable, and that the channel stays armed through a filtered packet and accepts the next matching one.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;

    typedef enum logic [1:0] {
        RX_WAIT = 2'd0,
        RX_TAKE = 2'd1,
        RX_SKIP = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        SEL_COUNT   = 2'd0,
        SEL_ADDR    = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_STATION = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic err;
        logic done;
        logic ie;
        logic prom;
        logic en;
    } ctrl_t;

    localparam int CTRL_ERR  = 15;
    localparam int CTRL_DONE = 7;
    localparam int CTRL_IE   = 6;
    localparam int CTRL_PROM = 1;
    localparam int CTRL_EN   = 0;

    function automatic logic [15:0] pack_ctrl(ctrl_t c);
        logic [15:0] r;
        r = '0;
        r[CTRL_ERR]  = c.err;
        r[CTRL_DONE] = c.done;
        r[CTRL_IE]   = c.ie;
        r[CTRL_PROM] = c.prom;
        r[CTRL_EN]   = c.en;
        return r;
    endfunction

endpackage

// File: rtl/rx_ones_counter.sv
module rx_ones_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         full
);
    localparam logic [W-1:0] ALL_ONES = '1;

    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (load) value <= load_val;
        else if (inc)  value <= value + 1'b1;
    end

    assign full = (value == ALL_ONES);

    // R9: the controller must never count a word once the count is exhausted
    assert_no_count_past_full_R9: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |-> !full);

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] station,
    input  logic [AW-1:0] dest,
    input  logic          prom,
    output logic          accept
);
    assign accept = prom || (dest == station);
endmodule

// File: rtl/rx_dma.sv
module rx_dma
    import rx_dma_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int WC_W   = 10,
    parameter int STA_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [STA_W-1:0]  station_sw,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              rx_last,
    input  logic              rx_crc_ok,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    input  logic              mem_ack,
    output logic              irq
);
    localparam int BA_W = WORD_W - 1;

    ctrl_t             ctrl_q;
    rx_state_e         st_q;
    logic [BA_W-1:0]   ba_q;
    logic              req_q;
    logic [WORD_W-1:0] data_q;
    logic [WC_W-1:0]   wc;
    logic              wc_full;
    logic              accept;

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_sel);

    logic wr_count, wr_addr, wr_ctrl;
    assign wr_count = reg_wr && (sel == SEL_COUNT);
    assign wr_addr  = reg_wr && (sel == SEL_ADDR);
    assign wr_ctrl  = reg_wr && (sel == SEL_CTRL);

    rx_dest_filter #(.AW(STA_W)) u_filter (
        .station (station_sw),
        .dest    (rx_data[WORD_W-1 -: STA_W]),
        .prom    (ctrl_q.prom),
        .accept  (accept)
    );

    // word classification for the current cycle
    logic hit, late, bad, fail, finish, count_inc, write_new;
    assign hit       = rx_valid && ctrl_q.en &&
                       ((st_q == RX_TAKE) || ((st_q == RX_WAIT) && accept));
    assign late      = req_q && !mem_ack;
    assign bad       = late || wc_full;
    assign fail      = bad || (rx_last && !rx_crc_ok);
    assign finish    = hit && (bad || rx_last);
    assign count_inc = hit && !bad;
    assign write_new = hit && !bad && !rx_last;

    rx_ones_counter #(.W(WC_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_count),
        .load_val (reg_wdata[WC_W-1:0]),
        .inc      (count_inc),
        .value    (wc),
        .full     (wc_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            st_q   <= RX_WAIT;
            ba_q   <= '0;
            req_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (wr_addr)              ba_q <= reg_wdata[WORD_W-1:1];
            else if (req_q && mem_ack) ba_q <= ba_q + 1'b1;

            if (write_new) begin
                req_q  <= 1'b1;
                data_q <= rx_data;
            end else if (finish && bad) begin
                req_q  <= 1'b0;
            end else if (mem_ack) begin
                req_q  <= 1'b0;
            end

            if (wr_ctrl) begin
                ctrl_q.ie   <= reg_wdata[CTRL_IE];
                ctrl_q.prom <= reg_wdata[CTRL_PROM];
                ctrl_q.en   <= reg_wdata[CTRL_EN];
                ctrl_q.err  <= 1'b0;
                ctrl_q.done <= 1'b0;
            end else if (finish) begin
                ctrl_q.en   <= 1'b0;
                ctrl_q.done <= 1'b1;
                ctrl_q.err  <= fail;
            end

            if (!ctrl_q.en || wr_ctrl || finish) begin
                st_q <= RX_WAIT;
            end else if (rx_valid) begin
                unique case (st_q)
                    RX_WAIT: st_q <= rx_last ? RX_WAIT : (accept ? RX_TAKE : RX_SKIP);
                    RX_TAKE: st_q <= rx_last ? RX_WAIT : RX_TAKE;
                    RX_SKIP: st_q <= rx_last ? RX_WAIT : RX_SKIP;
                    default: st_q <= RX_WAIT;
                endcase
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_COUNT:   reg_rdata = {{(WORD_W-WC_W){1'b0}}, wc};
            SEL_ADDR:    reg_rdata = {ba_q, 1'b0};
            SEL_CTRL:    reg_rdata = pack_ctrl(ctrl_q);
            SEL_STATION: reg_rdata = {{(WORD_W-STA_W){1'b0}}, station_sw};
            default:     reg_rdata = '0;
        endcase
    end

    assign mem_req  = req_q;
    assign mem_addr = {ba_q, 1'b0};
    assign mem_data = data_q;
    assign irq      = ctrl_q.done && ctrl_q.ie;

    // R5: a waiting write keeps address and data until acknowledged
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !wr_addr) |=>
            ((mem_req && $stable(mem_addr) && $stable(mem_data)) || ctrl_q.err));

    // R7: the check word never leaves a write pending
    assert_crc_not_written_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && rx_last) |=> !mem_req);

    // R3: a first word that fails the filter never starts a write
    assert_filter_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && ctrl_q.en && (st_q == RX_WAIT) && !accept) |=> !$rose(mem_req));

    // R12: a disabled channel never starts a write
    assert_ignore_disabled_R12: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !ctrl_q.en) |=> !$rose(mem_req));

    // R11: done can only rise together with enable falling
    assert_done_clears_en_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.done) |-> !ctrl_q.en);

endmodule

// File: tb/tb_rx_dma.sv
module tb_rx_dma;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  reg_sel;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [7:0]  station_sw;
    logic        rx_valid;
    logic [15:0] rx_data;
    logic        rx_last;
    logic        rx_crc_ok;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [15:0] mem_data;
    logic        mem_ack;
    logic        irq;

    always #5 clk = ~clk;

    rx_dma dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .station_sw(station_sw),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_crc_ok(rx_crc_ok), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_ack(mem_ack), .irq(irq)
    );

    int tests = 0;
    int fails = 0;
    int ack_delay = 0;
    int wait_cnt = 0;
    int nwrites = 0;
    logic [15:0] mem [0:255];

    localparam logic [7:0]  STATION = 8'h5A;
    localparam logic [15:0] BASE    = 16'h0100;

    typedef struct packed {
        logic [7:0] dest;
        logic       prom;
        logic [3:0] ndata;
        logic       crc_ok;
        logic [3:0] cnt;
        logic       exp_done;
        logic       exp_err;
        logic [3:0] exp_wr;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{8'h5A, 1'b0, 4'd3, 1'b1, 4'd4, 1'b1, 1'b0, 4'd3},  // R3 R7 normal
        '{8'h33, 1'b1, 4'd2, 1'b1, 4'd3, 1'b1, 1'b0, 4'd2},  // R4 promiscuous
        '{8'h5A, 1'b0, 4'd3, 1'b0, 4'd4, 1'b1, 1'b1, 4'd3},  // R8 bad check
        '{8'h5A, 1'b0, 4'd3, 1'b1, 4'd3, 1'b1, 1'b1, 4'd3},  // R9 count omits check word
        '{8'h5A, 1'b0, 4'd5, 1'b1, 4'd4, 1'b1, 1'b1, 4'd4},  // R9 too many data words
        '{8'h33, 1'b0, 4'd2, 1'b1, 4'd3, 1'b0, 1'b0, 4'd0},  // R3 filtered
        '{8'h5A, 1'b0, 4'd1, 1'b1, 4'd2, 1'b1, 1'b0, 4'd1}   // R7 header only
    };

    // memory responder
    initial begin
        mem_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt >= ack_delay) begin
                    mem[mem_addr[8:1]] = mem_data;
                    mem_ack  = 1'b1;
                    wait_cnt = 0;
                    nwrites++;
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        @(negedge clk);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic send(input logic [15:0] w, input logic last, input logic ok, input int gap);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = w; rx_last = last; rx_crc_ok = ok;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    function automatic logic [15:0] word_of(input int idx, input int k, input logic [7:0] d);
        if (k == 0) return {d, 8'(idx)};
        return 16'hA000 | 16'(idx << 4) | 16'(k);
    endfunction

    task automatic send_packet(input int idx, input logic [7:0] d, input int ndata,
                               input logic ok, input int gap);
        for (int k = 0; k < ndata; k++) send(word_of(idx, k, d), 1'b0, 1'b0, gap);
        send(16'hC3C3, 1'b1, ok, gap);
        repeat (4) @(negedge clk);
    endtask

    logic [15:0] v;

    initial begin
        rst = 1'b1; reg_sel = 2'd0; reg_wr = 1'b0; reg_wdata = '0;
        station_sw = STATION; rx_valid = 1'b0; rx_data = '0;
        rx_last = 1'b0; rx_crc_ok = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); chk("R1 count", v, 16'h0000);
        rd(2'd1, v); chk("R1 addr", v, 16'h0000);
        rd(2'd2, v); chk("R1 ctrl", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 mem_req", {15'd0, mem_req}, 16'd0);

        // R2 register fields
        rd(2'd3, v); chk("R2 station", v, 16'h005A);
        station_sw = 8'hA5;
        rd(2'd3, v); chk("R2 station follows switches", v, 16'h00A5);
        station_sw = STATION;
        wr(2'd3, 16'hFFFF);
        rd(2'd3, v); chk("R2 station read-only", v, 16'h005A);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); chk("R2 count width", v, 16'h03FF);
        wr(2'd1, 16'h1235);
        rd(2'd1, v); chk("R2 addr bit0", v, 16'h1234);
        wr(2'd2, 16'hFFFF);
        rd(2'd2, v); chk("R2 ctrl writable bits", v, 16'h0043);
        wr(2'd2, 16'h0000);

        // table of packet scenarios
        for (int i = 0; i < 7; i++) begin
            vec_t vv;
            int counted;
            vv = VECS[i];
            nwrites = 0;
            ack_delay = 0;
            wr(2'd0, {6'd0, ~{6'd0, vv.cnt}});
            wr(2'd1, BASE);
            wr(2'd2, 16'h0041 | (16'(vv.prom) << 1));
            send_packet(i, vv.dest, int'(vv.ndata), vv.crc_ok, 1);
            counted = 0;
            if (vv.exp_done)
                counted = (int'(vv.ndata) + 1 < int'(vv.cnt)) ? int'(vv.ndata) + 1 : int'(vv.cnt);
            rd(2'd2, v);
            chk($sformatf("R8 R9 R11 ctrl vec %0d", i), v,
                {vv.exp_err, 7'd0, vv.exp_done, 1'b1, 4'd0, vv.prom, ~vv.exp_done});
            rd(2'd0, v);
            chk($sformatf("R6 count vec %0d", i), v,
                16'(10'(~{6'd0, vv.cnt}) + 10'(counted)));
            rd(2'd1, v);
            chk($sformatf("R5 addr vec %0d", i), v, BASE + 16'(2 * int'(vv.exp_wr)));
            chk($sformatf("R7 writes vec %0d", i), 16'(nwrites), 16'(vv.exp_wr));
            for (int k = 0; k < int'(vv.exp_wr); k++)
                chk($sformatf("R5 data vec %0d word %0d", i, k),
                    mem[8'h80 + 8'(k)], word_of(i, k, vv.dest));
            chk($sformatf("R11 irq vec %0d", i), {15'd0, irq}, {15'd0, vv.exp_done});
        end

        // R3 channel stays armed through a filtered packet
        nwrites = 0;
        wr(2'd0, 16'h03FC);
        wr(2'd1, BASE);
        wr(2'd2, 16'h0041);
        send_packet(9, 8'h77, 2, 1'b1, 1);
        rd(2'd2, v); chk("R3 armed after filtered", v, 16'h0041);
        send_packet(10, STATION, 2, 1'b1, 1);
        rd(2'd2, v); chk("R3 next match done", v, 16'h00C0);
        rd(2'd0, v); chk("R6 count after filtered+match", v, 16'h03FF);
        chk("R3 writes only match", 16'(nwrites), 16'd2);
        chk("R3 first data", mem[8'h80], word_of(10, 0, STATION));

        // R11 interrupt gating and clear by write
        nwrites = 0;
        wr(2'd0, 16'h03FD);
        wr(2'd1, BASE);
        wr(2'd2, 16'h0001);
        send_packet(11, STATION, 1, 1'b1, 1);
        rd(2'd2, v); chk("R11 done without ie", v, 16'h0080);
        chk("R11 irq masked", {15'd0, irq}, 16'd0);
        wr(2'd2, 16'h0000);
        rd(2'd2, v); chk("R11 write clears done", v, 16'h0000);

        // R12 disabled channel ignores words
        nwrites = 0;
        wr(2'd0, 16'h03FB);
        send_packet(12, STATION, 3, 1'b1, 1);
        rd(2'd0, v); chk("R12 count unchanged", v, 16'h03FB);
        chk("R12 no writes", 16'(nwrites), 16'd0);
        rd(2'd2, v); chk("R12 no done", v, 16'h0000);

        // R10 memory too slow
        nwrites = 0;
        ack_delay = 10;
        wr(2'd0, 16'h03FB);
        wr(2'd1, BASE);
        wr(2'd2, 16'h0041);
        send(word_of(13, 0, STATION), 1'b0, 1'b0, 1);
        send(word_of(13, 1, STATION), 1'b0, 1'b0, 1);
        repeat (20) @(negedge clk);
        rd(2'd2, v); chk("R10 late error", v, 16'h80C0);
        chk("R10 request withdrawn", {15'd0, mem_req}, 16'd0);
        chk("R10 no write", 16'(nwrites), 16'd0);
        rd(2'd1, v); chk("R10 addr unchanged", v, BASE);
        ack_delay = 0;

        summary();
        $finish;
    end

endmodule